// File: doc/BRIEF.md
# I2C EEPROM Transaction Sequencer

This block is an I2C bus master that carries out one whole serial EEPROM access for each command it accepts. The caller gives the operation, a 7-bit device address, an 8-bit word address and, for a write, one data byte. The block then drives the bus by itself. It generates start, repeated start and stop conditions, shifts each byte out MSB first and checks the acknowledge that follows every byte it sends. When the command ends it returns either the byte read or an error indication.

A byte write runs as follows: start, device address with the write direction, word address, data byte, stop. A random read runs as follows: start, device address with the write direction, word address, repeated start, device address with the read direction, one received byte closed with NACK, stop. The caller never supplies the direction bit, because the sequencer sets it from the phase. Each bit takes four quarter slots, and SCL is derived from the system clock through a fixed divide by 16 followed by a programmable divide by `div_sel + 1`. Both lines are open-drain: the block only ever pulls them low.

The controller is a single state machine with these states: IDLE, START, SEND, ACK, RESTART, RECV, NACK and STOP. Its transitions are:
- IDLE goes to START when a command is accepted.
- START goes to SEND.
- SEND goes to ACK after the eighth bit.
- ACK goes to SEND for the next transmitted byte, to RESTART after the word address of a read, to RECV after the read address, or to STOP after the last write byte or on a missing ACK.
- RESTART goes to SEND.
- RECV goes to NACK after the eighth bit.
- NACK goes to STOP.
- STOP goes to IDLE and pulses `done`.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: A write command produces on the bus: a start, the byte {cmd_dev, 0}, cmd_word, cmd_wdata, then a stop. The block waits for an ACK after each of these bytes before it sends the next one.
- R2: Bit 0 of every address byte is set by the block. It is 0 in the phase before the repeated start and 1 in the phase after it. No input selects the direction.
- R3: A read command produces on the bus: a start, {cmd_dev, 0}, cmd_word, a repeated start, {cmd_dev, 1}, eight received bits taken MSB first, a NACK from the master (SDA released), then a stop. The received byte appears on rdata when done pulses and holds until the next read ends.
- R4: If any transmitted byte is not acknowledged (SDA high in its ACK slot), the block sends no further byte, issues a stop and pulses done with err = 1. A command that completes normally pulses done with err = 0. err holds its value while the block is idle and clears when the next command is accepted.
- R5: The SCL period during a byte is 16 × (div_sel + 1) system clock cycles.
- R6: SDA changes while SCL is released only to form a start, a repeated start or a stop. Acknowledge bits and received bits are sampled in the middle of the SCL high time.
- R7: scl_pull_low and sda_pull_low only ever pull a line low. Both are 0 after reset and at all times while busy is 0.
- R8: A command is accepted only when cmd_valid is high and busy is low, and busy rises only in the cycle after such a cycle. done is a one-cycle pulse that coincides with busy returning low. A cmd_valid while busy is high has no effect on the bus or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | DIV_W | SCL divider setting; the divide factor is div_sel + 1 |
| cmd_valid | input | 1 | Command request; taken when the block is idle |
| cmd_read | input | 1 | 1 = random read, 0 = byte write |
| cmd_dev | input | 7 | 7-bit device address |
| cmd_word | input | 8 | Word address inside the device |
| cmd_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| err | output | 1 | The last command saw a missing ACK |
| rdata | output | 8 | Byte returned by the last read |
| scl_pull_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_in | input | 1 | SDA level read back from the bus |

## Verification
The assertions assume three things about the inputs: div_sel stays constant while busy is high, no other master drives SCL, and nothing holds SCL low. Under these conditions every SDA change with SCL high can be traced to one of the START, RESTART or STOP states. The bench respects these assumptions. It changes div_sel only between commands, and its responding device model only pulls SDA low, and only while SCL is low. Missing ACKs are produced in two ways: by addressing a device that does not answer, and by having the model withhold its ACK on a chosen byte.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_ACK,
        ST_RESTART,
        ST_RECV,
        ST_NACK,
        ST_STOP
    } seq_state_t;

endpackage

// File: rtl/i2c_seq_tick.sv
module i2c_seq_tick #(
    parameter int PRE_DIV = 16,
    parameter int DIV_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    // one tick per quarter of an SCL period
    localparam int STEP = PRE_DIV / 4;
    localparam int SW   = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP - 1);

    logic [SW-1:0]    pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_wrap;

    assign pre_wrap = (pre_cnt == STEP_LAST);
    assign tick     = pre_wrap && (div_cnt == div_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= (div_cnt == div_sel) ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic       cmd_read,
    input  logic [6:0] cmd_dev,
    input  logic [7:0] cmd_word,
    input  logic [7:0] cmd_wdata,
    input  logic       sda_in,
    output logic       accept,
    output logic       busy,
    output logic       in_cond,
    output logic       done,
    output logic       err,
    output logic [7:0] rdata,
    output logic       scl_low,
    output logic       sda_low
);
    seq_state_t state, state_nx;
    logic [1:0] ph;
    logic [2:0] bitcnt;
    logic [1:0] idx;
    logic [7:0] shreg;
    logic       rd_op, nack_q, fail_q;
    logic [6:0] dev_q;
    logic [7:0] word_q, wdata_q;
    logic       slot_end, mid_high;

    assign slot_end = tick && (ph == 2'd3);
    assign mid_high = tick && (ph == 2'd2);
    assign accept   = (state == ST_IDLE) && cmd_valid;
    assign busy     = (state != ST_IDLE);
    assign in_cond  = (state == ST_START) || (state == ST_RESTART) || (state == ST_STOP);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_nx = ST_START;
            ST_START:   if (slot_end) state_nx = ST_SEND;
            ST_SEND:    if (slot_end && bitcnt == 3'd0) state_nx = ST_ACK;
            ST_ACK: begin
                if (slot_end) begin
                    if (nack_q)            state_nx = ST_STOP;
                    else if (idx == 2'd0)  state_nx = ST_SEND;
                    else if (idx == 2'd1)  state_nx = rd_op ? ST_RESTART : ST_SEND;
                    else                   state_nx = rd_op ? ST_RECV : ST_STOP;
                end
            end
            ST_RESTART: if (slot_end) state_nx = ST_SEND;
            ST_RECV:    if (slot_end && bitcnt == 3'd0) state_nx = ST_NACK;
            ST_NACK:    if (slot_end) state_nx = ST_STOP;
            ST_STOP:    if (slot_end) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ph      <= 2'd0;
            bitcnt  <= 3'd0;
            idx     <= 2'd0;
            shreg   <= 8'd0;
            rd_op   <= 1'b0;
            nack_q  <= 1'b0;
            fail_q  <= 1'b0;
            dev_q   <= 7'd0;
            word_q  <= 8'd0;
            wdata_q <= 8'd0;
            done    <= 1'b0;
            err     <= 1'b0;
            rdata   <= 8'd0;
        end else begin
            state <= state_nx;
            done  <= 1'b0;
            if (tick) ph <= ph + 2'd1;
            if (accept) begin
                ph      <= 2'd0;
                rd_op   <= cmd_read;
                dev_q   <= cmd_dev;
                word_q  <= cmd_word;
                wdata_q <= cmd_wdata;
                idx     <= 2'd0;
                fail_q  <= 1'b0;
                err     <= 1'b0;
            end
            if (mid_high && state == ST_ACK)  nack_q <= sda_in;
            if (mid_high && state == ST_RECV) shreg  <= {shreg[6:0], sda_in};
            if (slot_end) begin
                unique case (state)
                    ST_START: begin
                        shreg  <= {dev_q, 1'b0};
                        bitcnt <= 3'd7;
                    end
                    ST_SEND: begin
                        if (bitcnt != 3'd0) begin
                            bitcnt <= bitcnt - 3'd1;
                            shreg  <= {shreg[6:0], 1'b0};
                        end
                    end
                    ST_ACK: begin
                        bitcnt <= 3'd7;
                        if (nack_q) begin
                            fail_q <= 1'b1;
                        end else if (idx == 2'd0) begin
                            shreg <= word_q;
                            idx   <= 2'd1;
                        end else if (idx == 2'd1 && !rd_op) begin
                            shreg <= wdata_q;
                            idx   <= 2'd2;
                        end
                    end
                    ST_RESTART: begin
                        shreg  <= {dev_q, 1'b1};
                        idx    <= 2'd2;
                        bitcnt <= 3'd7;
                    end
                    ST_RECV: if (bitcnt != 3'd0) bitcnt <= bitcnt - 3'd1;
                    ST_NACK: rdata <= shreg;
                    ST_STOP: begin
                        done <= 1'b1;
                        err  <= fail_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // line outputs; slot phase 0 keeps SDA so it never moves on the SCL falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    scl_low <= 1'b0;
                    sda_low <= 1'b0;
                end
                ST_START: begin
                    scl_low <= (ph == 2'd3);
                    if (ph != 2'd0) sda_low <= (ph >= 2'd2);
                end
                ST_RESTART: begin
                    scl_low <= (ph < 2'd2);
                    if (ph != 2'd0) sda_low <= (ph == 2'd3);
                end
                ST_SEND: begin
                    scl_low <= (ph < 2'd2);
                    if (ph != 2'd0) sda_low <= !shreg[7];
                end
                ST_STOP: begin
                    scl_low <= (ph < 2'd2);
                    if (ph != 2'd0) sda_low <= (ph != 2'd3);
                end
                default: begin
                    scl_low <= (ph < 2'd2);
                    if (ph != 2'd0) sda_low <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq #(
    parameter int PRE_DIV = 16,
    parameter int DIV_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [6:0]       cmd_dev,
    input  logic [7:0]       cmd_word,
    input  logic [7:0]       cmd_wdata,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       rdata,
    output logic             scl_pull_low,
    output logic             sda_pull_low,
    input  logic             sda_in
);
    logic tick;
    logic accept;
    logic in_cond;

    i2c_seq_tick #(.PRE_DIV(PRE_DIV), .DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .div_sel (div_sel),
        .tick    (tick)
    );

    i2c_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_dev   (cmd_dev),
        .cmd_word  (cmd_word),
        .cmd_wdata (cmd_wdata),
        .sda_in    (sda_in),
        .accept    (accept),
        .busy      (busy),
        .in_cond   (in_cond),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .scl_low   (scl_pull_low),
        .sda_low   (sda_pull_low)
    );

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic in_cond,
    input logic scl_pull_low,
    input logic sda_pull_low
);
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull_low && !sda_pull_low));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    assert_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    assert_sda_framing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_low) && !scl_pull_low && !$past(scl_pull_low)) |-> $past(in_cond));

endmodule

bind i2c_eeprom_seq i2c_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .in_cond      (in_cond),
    .scl_pull_low (scl_pull_low),
    .sda_pull_low (sda_pull_low)
);

// File: tb/i2c_eeprom_seq_tb.sv
module i2c_eeprom_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = CLK_PERIOD / 4;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] div_sel = 4'd0;
    logic cmd_valid = 1'b0, cmd_read = 1'b0;
    logic [6:0] cmd_dev = 7'd0;
    logic [7:0] cmd_word = 8'd0, cmd_wdata = 8'd0;
    logic busy, done, err, scl_pull_low, sda_pull_low, sda_in;
    logic [7:0] rdata;
    logic slv_low = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_in = !(sda_pull_low || slv_low);

    i2c_eeprom_seq u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cmd_valid(cmd_valid),
        .cmd_read(cmd_read), .cmd_dev(cmd_dev), .cmd_word(cmd_word),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err),
        .rdata(rdata), .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
        .sda_in(sda_in)
    );

    int total = 0, bad = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---- responding EEPROM model: events -1 start, -2 stop, -3 master NACK, -4 master ACK
    logic [7:0] mem [256];
    int ev[$];
    int rises[$];
    int cyc = 0, bitn = 0, byten = 0, gcount = 0, nack_at = -1;
    logic [7:0] sh = 8'd0, ptr = 8'd0;
    bit ackslot = 0, txm = 0, txnext = 0, prev_scl = 1, prev_sda = 1, cur_scl, cur_sda, ack;

    always @(negedge clk) begin
        cyc++;
        cur_scl = !scl_pull_low;
        cur_sda = sda_in;
        if (!rst_n) begin
            slv_low = 0; bitn = 0; ackslot = 0; txm = 0; txnext = 0;
        end else if (prev_scl && cur_scl && prev_sda && !cur_sda) begin
            ev.push_back(-1);
            bitn = 0; byten = 0; ackslot = 0; txm = 0; txnext = 0; slv_low = 0;
        end else if (prev_scl && cur_scl && !prev_sda && cur_sda) begin
            ev.push_back(-2);
            bitn = 0; ackslot = 0; txm = 0; txnext = 0; slv_low = 0;
        end else if (!prev_scl && cur_scl) begin
            rises.push_back(cyc);
            if (txm) begin
                if (bitn == 8) begin
                    ev.push_back(cur_sda ? -3 : -4);
                    bitn = 9;
                    ptr++;
                end else if (bitn < 8) bitn++;
            end else if (!ackslot && bitn < 8) begin
                sh = {sh[6:0], cur_sda};
                bitn++;
            end
        end else if (prev_scl && !cur_scl) begin
            if (txm) begin
                slv_low = (bitn < 8) ? !mem[ptr][7 - bitn] : 1'b0;
            end else if (ackslot) begin
                ackslot = 0; bitn = 0; slv_low = 0;
                if (txnext) begin
                    txnext = 0; txm = 1;
                    slv_low = !mem[ptr][7];
                end
            end else if (bitn == 8) begin
                ev.push_back(int'(sh));
                ack = (gcount != nack_at);
                if (byten == 0) begin
                    ack = ack && (sh[7:1] == DEV);
                    txnext = sh[0] && ack;
                end else if (byten == 1) begin
                    if (ack) ptr = sh;
                end else if (ack) begin
                    mem[ptr] = sh;
                    ptr++;
                end
                byten++; gcount++;
                ackslot = 1;
                slv_low = ack;
            end
        end
        prev_scl = cur_scl;
        prev_sda = cur_sda;
    end

    // ---- per-clock reference of busy/done and idle line state (R7, R8)
    bit exp_busy = 0;
    always begin
        @(posedge clk);
        #QTR;
        if (rst_n) begin
            if (done) begin
                check(!busy && exp_busy, "R8", "done with busy low ending a command", {busy, exp_busy}, 2'b01);
                exp_busy = 0;
            end else begin
                check(busy == exp_busy, "R8", "busy against model", busy, exp_busy);
            end
            if (!busy)
                check(!scl_pull_low && !sda_pull_low, "R7", "lines released while idle",
                      {scl_pull_low, sda_pull_low}, 0);
        end
    end

    task automatic run_cmd(bit rd, logic [6:0] dev, logic [7:0] w, logic [7:0] d);
        ev.delete();
        rises.delete();
        gcount = 0;
        @(negedge clk);
        cmd_read = rd; cmd_dev = dev; cmd_word = w; cmd_wdata = d; cmd_valid = 1;
        @(posedge clk);
        exp_busy = 1;
        @(negedge clk);
        cmd_valid = 0;
        forever begin
            @(posedge clk);
            #QTR;
            if (done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_ev(int exp[$], string req);
        bit ok = (ev.size() == exp.size());
        if (ok) foreach (exp[i]) if (ev[i] != exp[i]) ok = 0;
        check(ok, req, "bus event trace length (contents match when ok)", ev.size(), exp.size());
        if (!ok) $display("  trace got %p want %p", ev, exp);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (5) @(negedge clk);
        // reset state (R7, R8)
        check(!busy && !done && !err, "R8", "reset flags", {busy, done, err}, 0);
        check(!scl_pull_low && !sda_pull_low, "R7", "reset lines", {scl_pull_low, sda_pull_low}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 R2: byte write, divider 0 (R5)
        run_cmd(0, DEV, 8'h10, 8'hA5);
        check_ev('{-1, 8'hA0, 8'h10, 8'hA5, -2}, "R1");
        check(err == 0, "R4", "err after good write", err, 0);
        check(rises.size() > 1 && rises[1] - rises[0] == 16, "R5", "SCL period div 0",
              rises.size() > 1 ? rises[1] - rises[0] : -1, 16);

        // R3 R2: random read back
        run_cmd(1, DEV, 8'h10, 8'h00);
        check_ev('{-1, 8'hA0, 8'h10, -1, 8'hA1, -3, -2}, "R3");
        check(rdata == 8'hA5, "R3", "read data", rdata, 8'hA5);
        check(err == 0, "R4", "err after good read", err, 0);

        // R5: divider 3, read unwritten location
        div_sel = 4'd3;
        run_cmd(1, DEV, 8'h33, 8'h00);
        check(rdata == (8'h33 ^ 8'h5A), "R3", "read pattern byte", rdata, 8'h33 ^ 8'h5A);
        check(rises.size() > 1 && rises[1] - rises[0] == 64, "R5", "SCL period div 3",
              rises.size() > 1 ? rises[1] - rises[0] : -1, 64);
        div_sel = 4'd0;

        // R4: device does not answer its address
        run_cmd(0, 7'h51, 8'h10, 8'h11);
        check_ev('{-1, 8'hA2, -2}, "R4");
        check(err == 1, "R4", "err on address NACK", err, 1);

        // R4: word address not acknowledged in a read
        nack_at = 1;
        run_cmd(1, DEV, 8'h44, 8'h00);
        check_ev('{-1, 8'hA0, 8'h44, -2}, "R4");
        check(err == 1, "R4", "err on word NACK", err, 1);

        // R4: data byte not acknowledged, location keeps its value
        nack_at = 2;
        run_cmd(0, DEV, 8'h10, 8'h3C);
        check_ev('{-1, 8'hA0, 8'h10, 8'h3C, -2}, "R4");
        check(err == 1, "R4", "err on data NACK", err, 1);
        nack_at = -1;
        run_cmd(1, DEV, 8'h10, 8'h00);
        check(rdata == 8'hA5, "R4", "location after refused write", rdata, 8'hA5);
        check(err == 0, "R4", "err cleared by next good command", err, 0);

        // R4 R2: read-direction address refused after repeated start
        nack_at = 2;
        run_cmd(1, DEV, 8'h10, 8'h00);
        check_ev('{-1, 8'hA0, 8'h10, -1, 8'hA1, -2}, "R4");
        check(err == 1, "R4", "err on read address NACK", err, 1);
        check(rdata == 8'hA5, "R3", "rdata held after failed read", rdata, 8'hA5);
        nack_at = -1;

        // R8: command request while busy is ignored
        fork
            run_cmd(0, DEV, 8'h20, 8'h77);
            begin
                repeat (100) @(negedge clk);
                cmd_read = 1; cmd_dev = 7'h51; cmd_word = 8'hEE; cmd_valid = 1;
                @(negedge clk);
                cmd_valid = 0;
            end
        join
        check_ev('{-1, 8'hA0, 8'h20, 8'h77, -2}, "R8");
        repeat (60) @(negedge clk);
        check(ev.size() == 5 && !busy, "R8", "no second transaction", ev.size(), 5);
        run_cmd(1, DEV, 8'h20, 8'h00);
        check(rdata == 8'h77, "R1", "written byte read back", rdata, 8'h77);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule